// File: doc/BRIEF.md
# Daisy-Chainable Serial Angle Link

This block is the serial slave side of an angle sensor. A controller drives a serial clock. The first rising edge of that clock captures the current corrected 8-bit position, an error flag and a 4-bit CRC seed into a frame register. The data line then answers with a low acknowledge and holds low for a configurable processing hold-off. It then raises a start level and shifts out the position most significant bit first, followed by the error bit and a 4-bit CRC. The CRC is seeded and covers the nine payload bits. If the controller keeps clocking after the frame, the block passes on the level of its serial input one bit per edge. Several devices can therefore be chained so that one long clock burst reads every device in turn.

The serial clock, serial input and power-save input are asynchronous to the system clock and are synchronized before use. When the serial clock stays quiet for a set number of system cycles, the transfer ends, the data line goes high and a new capture becomes possible. In slow scanning mode the block also has a power-save handoff. A device that has sent its whole frame and then timed out drives its enable output low to wake the next device, and from then on passes its serial input straight through. A high power-save input puts the device to sleep, which resets the chain.

Top module: `angle_serial_link`

## Requirements
- R1: During and after reset the serial data output is high and the device is idle. The next-device enable output is high while reset is asserted.
- R2: The position, error flag and seed are captured on the first serial clock rising edge of a transfer. Changes to them later in the same transfer do not alter the frame that is sent.
- R3: On the capturing edge the data output goes low (acknowledge). It stays low for HOLD_EDGES further edges (default 2). On the next edge, edge number HOLD_EDGES+2, it goes high (start).
- R4: Each of the following edges presents one payload bit: position bit 7 down to bit 0, then the error flag (1 = error).
- R5: The next four edges present CRC bits 3 down to 0. The CRC register starts at the seed and takes the 9 payload bits most significant first with generator x^4+x+1. Each bit b is folded in as: feedback = crc[3] xor b, shift left one place, then xor 4'b0011 when feedback is 1.
- R6: Every edge after the last CRC bit presents the serial input level that was present at that edge.
- R7: If no serial clock edge arrives for QUIET_CYCLES system cycles during a transfer, the data output returns high. The next edge then starts a new transfer with a fresh capture.
- R8: While the power-save input is high, the data output stays high, serial clock edges are ignored and the next-device enable is high. A transfer always restarts from idle after release.
- R9: In slow scanning mode the next-device enable stays high until a complete frame has been sent and the quiet timeout has expired. It then goes low, and the data output follows the serial input continuously with no new frame on later edges.
- R10: In slow scanning mode a timeout that arrives before the frame is complete leaves the next-device enable high and returns the device to idle.
- R11: In fast scanning mode the next-device enable follows the power-save input with one system cycle of delay, so it is low while the device is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from the controller (asynchronous) |
| sdi_in | input | 1 | Serial data from the next device in the chain (asynchronous) |
| sleep_in | input | 1 | Power-save input, high puts the device to sleep (asynchronous) |
| slow_mode | input | 1 | 1 selects slow scanning with handoff, 0 selects fast scanning; quasi-static |
| pos_in | input | 8 | Corrected angle position, binary |
| err_in | input | 1 | Error flag, 1 = error |
| seed_in | input | 4 | CRC start value |
| sdo_out | output | 1 | Serial data output |
| next_n_out | output | 1 | Power-save output to the next device, low enables it |

## Verification
A wrong hold-off count or frame bit counter shifts the start level or the payload by whole serial clock periods. That shows on the data output at the first affected edge, about three system cycles after the synchronized rise. A corrupted CRC state or a capture that is not held shows only in the last four bits or in the payload bits, so each bit of several frames is compared against a reference computed from the inputs that were present at capture time. Faults in the timeout or the handoff state show as a data line that does not return high, or as an enable that falls too early or never. These are checked just before and just after the quiet window expires.

// File: rtl/angle_link_pkg.sv
package angle_link_pkg;

    localparam int POS_W     = 8;
    localparam int CRC_W     = 4;
    localparam int PAYLOAD_W = POS_W + 1;
    localparam int FRAME_W   = PAYLOAD_W + CRC_W;

    // Low-order taps of the generator x^4 + x + 1
    localparam logic [CRC_W-1:0] CRC_TAPS = 4'b0011;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_DATA,
        PH_FWD,
        PH_DONE,
        PH_SLEEP
    } phase_e;

    // Transmit order is the packed order: pos MSB first, then err, then crc MSB first
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             err;
        logic [CRC_W-1:0] crc;
    } frame_t;

    function automatic logic [CRC_W-1:0] crc_fold(
        input logic [CRC_W-1:0]     seed,
        input logic [PAYLOAD_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = seed;
        for (int i = PAYLOAD_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) begin
                c = c ^ CRC_TAPS;
            end
        end
        return c;
    endfunction

    function automatic frame_t build_frame(
        input logic [POS_W-1:0] pos,
        input logic             err,
        input logic [CRC_W-1:0] seed
    );
        frame_t f;
        f.pos = pos;
        f.err = err;
        f.crc = crc_fold(seed, {pos, err});
        return f;
    endfunction

    function automatic logic phase_active(input phase_e p);
        return (p == PH_HOLD) || (p == PH_DATA) || (p == PH_FWD);
    endfunction

endpackage

// File: rtl/asl_input_sync.sv
module asl_input_sync #(
    parameter int          STAGES  = 2,
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RST_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/asl_quiet_timer.sv
module asl_quiet_timer #(
    parameter int LIMIT = 1875
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic rise_i,
    output logic timeout_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i || rise_i) begin
            count_q <= '0;
        end else if (count_q != CNT_W'(LIMIT)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign timeout_o = active_i && !rise_i && (count_q == CNT_W'(LIMIT - 1));

    // R7
    quiet_restart_chk: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> (count_q == '0));

    // R7
    single_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

endmodule

// File: rtl/asl_frame_engine.sv
module asl_frame_engine
    import angle_link_pkg::*;
#(
    parameter int HOLD_EDGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             sdi_i,
    input  logic             sleep_i,
    input  logic             slow_i,
    input  logic             timeout_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             err_i,
    input  logic [CRC_W-1:0] seed_i,
    output logic             sdo_o,
    output logic             active_o,
    output logic             handoff_o
);

    localparam int HOLD_W = (HOLD_EDGES > 0) ? $clog2(HOLD_EDGES + 1) : 1;
    localparam int BIT_W  = $clog2(FRAME_W);

    phase_e              phase_q;
    frame_t              shreg_q;
    logic [HOLD_W-1:0]   hold_q;
    logic [BIT_W-1:0]    bit_q;
    logic                sdo_q;
    logic                handoff_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            shreg_q   <= '0;
            hold_q    <= '0;
            bit_q     <= '0;
            sdo_q     <= 1'b1;
            handoff_q <= 1'b0;
        end else begin
            handoff_q <= 1'b0;
            if (sleep_i) begin
                phase_q <= PH_SLEEP;
                sdo_q   <= 1'b1;
            end else begin
                unique case (phase_q)
                    PH_SLEEP: begin
                        phase_q <= PH_IDLE;
                        sdo_q   <= 1'b1;
                    end
                    PH_IDLE: begin
                        if (rise_i) begin
                            shreg_q <= build_frame(pos_i, err_i, seed_i);
                            hold_q  <= '0;
                            sdo_q   <= 1'b0;
                            phase_q <= PH_HOLD;
                        end
                    end
                    PH_HOLD: begin
                        if (timeout_i) begin
                            phase_q <= PH_IDLE;
                            sdo_q   <= 1'b1;
                        end else if (rise_i) begin
                            if (hold_q == HOLD_W'(HOLD_EDGES)) begin
                                sdo_q   <= 1'b1;
                                bit_q   <= '0;
                                phase_q <= PH_DATA;
                            end else begin
                                hold_q  <= hold_q + 1'b1;
                                sdo_q   <= 1'b0;
                            end
                        end
                    end
                    PH_DATA: begin
                        if (timeout_i) begin
                            phase_q <= PH_IDLE;
                            sdo_q   <= 1'b1;
                        end else if (rise_i) begin
                            sdo_q   <= shreg_q[FRAME_W-1];
                            shreg_q <= frame_t'({shreg_q} << 1);
                            bit_q   <= bit_q + 1'b1;
                            if (bit_q == BIT_W'(FRAME_W - 1)) begin
                                phase_q <= PH_FWD;
                            end
                        end
                    end
                    PH_FWD: begin
                        if (timeout_i) begin
                            if (slow_i) begin
                                phase_q   <= PH_DONE;
                                handoff_q <= 1'b1;
                                sdo_q     <= sdi_i;
                            end else begin
                                phase_q   <= PH_IDLE;
                                sdo_q     <= 1'b1;
                            end
                        end else if (rise_i) begin
                            sdo_q <= sdi_i;
                        end
                    end
                    PH_DONE: begin
                        sdo_q <= sdi_i;
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        sdo_q   <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign sdo_o     = sdo_q;
    assign active_o  = phase_active(phase_q);
    assign handoff_o = handoff_q;

    // R3
    ack_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_i && !sleep_i && phase_q == PH_IDLE) |=> !sdo_q);

    // R3
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_i && !sleep_i && !timeout_i && phase_q == PH_HOLD
         && hold_q == HOLD_W'(HOLD_EDGES)) |=> sdo_q);

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) |-> sdo_q);

    // R8
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SLEEP) |-> sdo_q);

    // R9
    handoff_done_chk: assert property (@(posedge clk) disable iff (rst)
        handoff_q |-> (phase_q == PH_DONE));

endmodule

// File: rtl/asl_chain_power.sv
module asl_chain_power (
    input  logic clk,
    input  logic rst,
    input  logic sleep_i,
    input  logic slow_i,
    input  logic handoff_i,
    output logic next_n_o
);

    logic next_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_n_q <= 1'b1;
        end else if (sleep_i) begin
            next_n_q <= 1'b1;
        end else if (!slow_i) begin
            next_n_q <= 1'b0;
        end else if (handoff_i) begin
            next_n_q <= 1'b0;
        end
    end

    assign next_n_o = next_n_q;

    // R8
    sleep_next_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> next_n_q);

    // R9
    hand_low_chk: assert property (@(posedge clk) disable iff (rst)
        (slow_i && !sleep_i && handoff_i) |=> !next_n_q);

    // R11
    fast_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !slow_i |=> (next_n_q == $past(sleep_i)));

endmodule

// File: rtl/angle_serial_link.sv
module angle_serial_link
    import angle_link_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int HOLD_EDGES   = 2,
    parameter int QUIET_CYCLES = 1875
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_in,
    input  logic             sdi_in,
    input  logic             sleep_in,
    input  logic             slow_mode,
    input  logic [POS_W-1:0] pos_in,
    input  logic             err_in,
    input  logic [CRC_W-1:0] seed_in,
    output logic             sdo_out,
    output logic             next_n_out
);

    localparam int SYNC_W = 3;
    localparam logic [SYNC_W-1:0] SYNC_RST = 3'b100;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] synced;
    logic              sclk_s, sdi_s, sleep_s;
    logic              sclk_prev_q;
    logic              rise;
    logic              active, timeout, handoff;

    assign raw_in = {sleep_in, sdi_in, sclk_in};

    asl_input_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (SYNC_W),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    assign sclk_s  = synced[0];
    assign sdi_s   = synced[1];
    assign sleep_s = synced[2];

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b0;
        else     sclk_prev_q <= sclk_s;
    end

    assign rise = sclk_s && !sclk_prev_q;

    asl_quiet_timer #(
        .LIMIT (QUIET_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .rise_i    (rise),
        .timeout_o (timeout)
    );

    asl_frame_engine #(
        .HOLD_EDGES (HOLD_EDGES)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise),
        .sdi_i     (sdi_s),
        .sleep_i   (sleep_s),
        .slow_i    (slow_mode),
        .timeout_i (timeout),
        .pos_i     (pos_in),
        .err_i     (err_in),
        .seed_i    (seed_in),
        .sdo_o     (sdo_out),
        .active_o  (active),
        .handoff_o (handoff)
    );

    asl_chain_power u_power (
        .clk       (clk),
        .rst       (rst),
        .sleep_i   (sleep_s),
        .slow_i    (slow_mode),
        .handoff_i (handoff),
        .next_n_o  (next_n_out)
    );

endmodule

// File: tb/angle_serial_link_bench.sv
module angle_serial_link_bench;

    localparam int HALF = 8;
    localparam int HOLD = 2;
    localparam int TMO  = 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sleep = 1'b0;
    logic       slow = 1'b0;
    logic [7:0] pos = '0;
    logic       err = 1'b0;
    logic [3:0] seed = '0;
    logic       sdo;
    logic       next_n;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    angle_serial_link #(
        .SYNC_STAGES  (2),
        .HOLD_EDGES   (HOLD),
        .QUIET_CYCLES (TMO)
    ) u_angle_serial_link (
        .clk        (clk),
        .rst        (rst),
        .sclk_in    (sclk),
        .sdi_in     (sdi),
        .sleep_in   (sleep),
        .slow_mode  (slow),
        .pos_in     (pos),
        .err_in     (err),
        .seed_in    (seed),
        .sdo_out    (sdo),
        .next_n_out (next_n)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Reference CRC by polynomial division of seed*x^9 + msg*x^4 by x^4+x+1
    function automatic logic [3:0] ref_crc(input logic [3:0] s, input logic [8:0] m);
        logic [12:0] v;
        v = {s, 9'b0} ^ {m, 4'b0};
        for (int i = 12; i >= 4; i--) begin
            if (v[i]) v[i -: 5] = v[i -: 5] ^ 5'b10011;
        end
        return v[3:0];
    endfunction

    // One serial clock period; returns sdo just before the next rise
    task automatic clk_edge(input logic d, output logic q);
        @(negedge clk) sdi = d;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
        repeat (HALF - 2) @(negedge clk);
        q = sdo;
    endtask

    task automatic wait_quiet();
        repeat (TMO + 20) @(negedge clk);
    endtask

    task automatic do_frame(input logic [7:0] p, input logic e, input logic [3:0] s, input bit alter);
        logic        q;
        logic [12:0] w;
        string       tag;
        pos = p; err = e; seed = s;
        w = {p, e, ref_crc(s, {p, e})};
        clk_edge(1'b0, q);
        check("R3", "ack level", q, 1'b0);
        if (alter) begin
            pos = ~p; err = ~e; seed = ~s;
        end
        for (int h = 0; h < HOLD; h++) begin
            clk_edge(1'b0, q);
            check("R3", "hold-off level", q, 1'b0);
        end
        clk_edge(1'b0, q);
        check("R3", "start level", q, 1'b1);
        for (int i = 12; i >= 0; i--) begin
            clk_edge(1'b0, q);
            tag = alter ? "R2" : ((i >= 4) ? "R4" : "R5");
            check(tag, $sformatf("frame bit %0d", i), q, w[i]);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "sdo in reset", sdo, 1'b1);
        check("R1", "next_n in reset", next_n, 1'b1);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check("R1", "sdo after reset", sdo, 1'b1);
        check("R11", "next_n awake fast", next_n, 1'b0);
    endtask

    task automatic t_fast_frames();
        do_frame(8'hA5, 1'b0, 4'h3, 1'b0);
        wait_quiet();
        check("R7", "sdo after timeout", sdo, 1'b1);
        do_frame(8'h3C, 1'b1, 4'h9, 1'b1);
        wait_quiet();
        do_frame(8'h00, 1'b0, 4'h0, 1'b0);
        wait_quiet();
    endtask

    task automatic t_forward();
        logic       q;
        logic [5:0] pat;
        pat = 6'b101100;
        do_frame(8'hFF, 1'b1, 4'hF, 1'b0);
        for (int i = 5; i >= 0; i--) begin
            clk_edge(pat[i], q);
            check("R6", $sformatf("forwarded bit %0d", i), q, pat[i]);
        end
        wait_quiet();
        check("R7", "sdo after forward timeout", sdo, 1'b1);
        do_frame(8'h5A, 1'b0, 4'hC, 1'b0);
        wait_quiet();
    endtask

    task automatic t_sleep();
        logic q;
        sleep = 1'b1;
        repeat (6) @(negedge clk);
        check("R8", "next_n asleep", next_n, 1'b1);
        for (int i = 0; i < 3; i++) begin
            clk_edge(1'b0, q);
            check("R8", "sdo ignores clock asleep", q, 1'b1);
        end
        sleep = 1'b0;
        repeat (6) @(negedge clk);
        check("R11", "next_n after wake", next_n, 1'b0);
        do_frame(8'h12, 1'b0, 4'h5, 1'b0);
        wait_quiet();
    endtask

    task automatic t_slow();
        logic q;
        sleep = 1'b1;
        repeat (6) @(negedge clk);
        slow = 1'b1;
        repeat (2) @(negedge clk);
        sleep = 1'b0;
        repeat (6) @(negedge clk);
        check("R9", "next_n before frame", next_n, 1'b1);
        for (int i = 0; i < 5; i++) clk_edge(1'b0, q);
        wait_quiet();
        check("R10", "next_n after partial", next_n, 1'b1);
        check("R10", "sdo after partial", sdo, 1'b1);
        do_frame(8'h81, 1'b0, 4'h6, 1'b0);
        check("R9", "next_n before timeout", next_n, 1'b1);
        wait_quiet();
        check("R9", "next_n after handoff", next_n, 1'b0);
        @(negedge clk) sdi = 1'b1;
        repeat (6) @(negedge clk);
        check("R9", "pass-through high", sdo, 1'b1);
        sdi = 1'b0;
        repeat (6) @(negedge clk);
        check("R9", "pass-through low", sdo, 1'b0);
        clk_edge(1'b1, q);
        check("R9", "no new frame after handoff", q, 1'b1);
        sleep = 1'b1;
        repeat (6) @(negedge clk);
        check("R8", "next_n on chain reset", next_n, 1'b1);
        check("R8", "sdo on chain reset", sdo, 1'b1);
        slow = 1'b0;
        sleep = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_fast_frames();
        t_forward();
        t_sleep();
        t_slow();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule